// File: doc/BRIEF.md
# Three-Wire Serial Memory Write Slave

This block is a slave on a three-wire serial bus made of a bus clock, a bidirectional open-drain data line and a separate enable line that frames each transfer. A fast system clock oversamples all three bus lines, finds start and stop events on the enable line, and shifts bytes in. After a start, the master sends a chip-address byte. If that byte names this device, the master sends a word address and then any number of data bytes. These bytes land in an internal 128-location by 8-bit array. The address steps forward after each stored byte.

After each stored byte, a timer models the write time of a non-volatile array. While the timer runs, a new data byte is refused with no acknowledge and is not stored. The master is expected to send that byte again once the timer has run out. The acknowledge is an output-enable that only ever pulls the data line low. A combinational peek port reads any location of the array back.

Top module: `tws_mem_slave`

## Requirements
- R1: With the bus clock high, a falling edge on the enable line begins a transfer. A rising edge on the enable line ends it. After the end, bytes clocked on the bus get no acknowledge until the next begin.
- R2: Each bit is sampled at the rising edge of the bus clock. Bytes are sent most significant bit first.
- R3: The first byte after a begin is acknowledged only when it equals 1010 0 s1 s0 0 (MSB first), where s1 and s0 are the second and third least significant bits (byte[2:1]) and must equal sel_i[1:0]. Any other value, including a 1 in bit 0 (a read), gets no acknowledge. All later bytes of that transfer are then ignored and nothing is written.
- R4: To acknowledge a byte, dat_pull_o goes high from the falling bus clock edge after the eighth bit until the falling edge after the ninth bit. It is low at all other times.
- R5: The byte after an accepted chip address is always acknowledged. Its low 7 bits become the current address, and its bit 7 is ignored.
- R6: Each accepted data byte is stored at the current address and acknowledged. The address then increments, wrapping from 127 to 0. A transfer may hold any number of data bytes.
- R7: Each stored byte starts a write window of WR_CYCLES system clocks. A data byte that completes inside the window gets no acknowledge, is not stored, and does not advance the address.
- R8: After the window ends, a resent byte is acknowledged and stored at the address that follows the last stored byte.
- R9: A begin event at any point, including mid-byte, drops the current transfer and restarts chip-address reception.
- R10: While reset is asserted and after it is released, dat_pull_o is low and the block waits for a begin.
- R11: peek_data_o shows the byte stored at peek_addr_i with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock |
| bus_en_i | input | 1 | Transfer framing line (begin/end) |
| bus_dat_i | input | 1 | Data line as seen on the wire |
| sel_i | input | 2 | Strapped chip-select value |
| dat_pull_o | output | 1 | When high, the data line is pulled low |
| peek_addr_i | input | ADDR_W | Array read address |
| peek_data_o | output | 8 | Array read data |

## Verification
The bench builds the block with WR_CYCLES set to 1000 and runs the bus with a half-period of 20 system clocks. One byte then takes about 360 clocks, so a data byte sent right after a stored one completes inside the write window and must be refused. A pause of 1100 clocks clears the window, so the resend and address-wrap cases fit in a short run. At this bus speed the two synchronizer flops and the edge register add only a few clocks of delay, which the master model allows for when it samples the acknowledge.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHIP  = 2'd1,
    ST_WADDR = 2'd2,
    ST_DATA  = 2'd3
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg1_q[g] <= 1'b1;
          stg2_q[g] <= 1'b1;
        end else begin
          stg1_q[g] <= d_i[g];
          stg2_q[g] <= stg1_q[g];
        end
      end
    end
  endgenerate

  assign q_o = stg2_q;
endmodule

// File: rtl/tws_busy_timer.sv
module tws_busy_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (go_i)
      cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  // R7
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o);

  // R8
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == CW'(1)));
endmodule

// File: rtl/tws_mem_array.sv
module tws_mem_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R6
  known_waddr_chk: assert property (@(posedge clk)
    we_i |-> !$isunknown(waddr_i));
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int          WR_CYCLES = 500000,
  parameter logic [3:0]  DEV_CODE  = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              bus_en_i,
  input  logic              bus_dat_i,
  input  logic [1:0]        sel_i,
  output logic              dat_pull_o,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [BYTE_W-1:0] peek_data_o
);
  localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(BYTE_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  // reset: asserted asynchronously, released on clk
  logic [1:0] rst_q;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_in_n = rst_q[1];

  // bus line sampling
  logic [2:0] sync_w;
  logic [2:0] prev_q;
  tws_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_in_n),
    .d_i   ({bus_clk_i, bus_en_i, bus_dat_i}),
    .q_o   (sync_w)
  );
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) prev_q <= 3'b111;
    else           prev_q <= sync_w;
  end

  logic s_clk, s_en, s_dat, p_clk, p_en;
  assign {s_clk, s_en, s_dat} = sync_w;
  assign p_clk = prev_q[2];
  assign p_en  = prev_q[1];

  logic clk_rise, clk_fall, begin_det, end_det;
  assign clk_rise  = s_clk & ~p_clk;
  assign clk_fall  = ~s_clk & p_clk;
  assign begin_det = s_clk & p_clk & p_en & ~s_en;
  assign end_det   = s_clk & p_clk & ~p_en & s_en;

  // protocol state
  tws_state_e        st_q, st_d;
  logic [BIT_CW-1:0] bc_q, bc_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] ad_q, ad_d;
  logic              ack_q, ack_d;
  logic              oe_q, oe_d;
  logic              mem_we, wr_go, busy;
  logic [BYTE_W-1:0] byte_w;
  logic              chip_ok;

  assign byte_w  = {sh_q[BYTE_W-2:0], s_dat};
  assign chip_ok = (byte_w[7:4] == DEV_CODE) && !byte_w[3] &&
                   (byte_w[2:1] == sel_i) && !byte_w[0];

  always_comb begin
    st_d   = st_q;
    bc_d   = bc_q;
    sh_d   = sh_q;
    ad_d   = ad_q;
    ack_d  = ack_q;
    oe_d   = oe_q;
    mem_we = 1'b0;
    wr_go  = 1'b0;
    if (begin_det) begin
      st_d  = ST_CHIP;
      bc_d  = '0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else if (end_det) begin
      st_d  = ST_IDLE;
      bc_d  = '0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (clk_rise) begin
        if (bc_q == ACK_SLOT) begin
          bc_d = '0;
        end else begin
          sh_d = byte_w;
          bc_d = bc_q + 1'b1;
          if (bc_q == LAST_BIT) begin
            unique case (st_q)
              ST_CHIP: begin
                ack_d = chip_ok;
                st_d  = chip_ok ? ST_WADDR : ST_IDLE;
              end
              ST_WADDR: begin
                ad_d  = byte_w[ADDR_W-1:0];
                ack_d = 1'b1;
                st_d  = ST_DATA;
              end
              ST_DATA: begin
                ack_d = !busy;
                if (!busy) begin
                  mem_we = 1'b1;
                  wr_go  = 1'b1;
                  ad_d   = ad_q + 1'b1;
                end
              end
              default: ack_d = 1'b0;
            endcase
          end
        end
      end else if (clk_fall) begin
        oe_d = (bc_q == ACK_SLOT) && ack_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      st_q  <= ST_IDLE;
      bc_q  <= '0;
      sh_q  <= '0;
      ad_q  <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bc_q  <= bc_d;
      sh_q  <= sh_d;
      ad_q  <= ad_d;
      ack_q <= ack_d;
      oe_q  <= oe_d;
    end
  end

  assign dat_pull_o = oe_q;

  tws_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .go_i   (wr_go),
    .busy_o (busy)
  );

  tws_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (ad_q),
    .wdata_i (byte_w),
    .raddr_i (peek_addr_i),
    .rdata_o (peek_data_o)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (st_q == ST_IDLE) |-> !dat_pull_o);

  // R4
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    dat_pull_o |-> (bc_q == ACK_SLOT || bc_q == '0));

  // R7
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    mem_we |-> !busy);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    mem_we |=> (ad_q == ADDR_W'($past(ad_q) + 1'b1)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    begin_det |=> (st_q == ST_CHIP && bc_q == '0 && !dat_pull_o));
endmodule

// File: tb/sim_tws_mem_slave.sv
module sim_tws_mem_slave;
  localparam int HALF = 20;
  localparam int WRC  = 1000;
  localparam int NVEC = 8;

  // {sel, chip, waddr, data, expect_ack, expect_mem}
  localparam logic [34:0] VEC [NVEC] = '{
    {2'b00, 8'hA0, 8'h10, 8'h11, 1'b1, 8'h11},
    {2'b01, 8'hA2, 8'h20, 8'h22, 1'b1, 8'h22},
    {2'b10, 8'hA4, 8'h7F, 8'h33, 1'b1, 8'h33},
    {2'b11, 8'hA6, 8'h8F, 8'h44, 1'b1, 8'h44},
    {2'b11, 8'hA2, 8'h10, 8'h55, 1'b0, 8'h11},
    {2'b00, 8'hB0, 8'h20, 8'h66, 1'b0, 8'h22},
    {2'b00, 8'hA8, 8'h7F, 8'h77, 1'b0, 8'h33},
    {2'b00, 8'hA1, 8'h0F, 8'h88, 1'b0, 8'h44}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_clk, m_en, m_dat;
  logic [1:0] sel;
  logic       pull;
  logic [6:0] paddr;
  logic [7:0] pdata;
  logic       line;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;
  assign line = m_dat & ~pull;

  tws_mem_slave #(.ADDR_W(7), .WR_CYCLES(WRC)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_clk_i   (m_clk),
    .bus_en_i    (m_en),
    .bus_dat_i   (line),
    .sel_i       (sel),
    .dat_pull_o  (pull),
    .peek_addr_i (paddr),
    .peek_data_o (pdata)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_begin();
    m_clk = 1'b0; wt(HALF);
    m_en = 1'b1; m_dat = 1'b1; wt(HALF);
    m_clk = 1'b1; wt(HALF);
    m_en = 1'b0; wt(HALF);
    m_clk = 1'b0; wt(HALF);
  endtask

  task automatic bus_end();
    m_clk = 1'b0; m_en = 1'b0; wt(HALF);
    m_clk = 1'b1; wt(HALF);
    m_en = 1'b1; wt(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_dat = b[i]; wt(HALF);
      m_clk = 1'b1; wt(HALF / 2);
      if (i == 7) chk(pull == 1'b0, "R4 released in data bit", pull, 0);
      wt(HALF / 2);
      m_clk = 1'b0;
    end
    m_dat = 1'b1; wt(HALF);
    m_clk = 1'b1; wt(HALF / 2);
    a = pull;
    wt(HALF / 2);
    m_clk = 1'b0;
  endtask

  function automatic logic [7:0] peek(input logic [6:0] a);
    paddr = a;
    return pdata;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] v;
    rst_n = 1'b0; m_clk = 1'b1; m_en = 1'b1; m_dat = 1'b1;
    sel = 2'b00; paddr = '0;
    wt(3);
    chk(pull == 1'b0, "R10 in reset", pull, 0);
    rst_n = 1'b1;
    wt(10);
    chk(pull == 1'b0, "R10 after reset", pull, 0);

    // table walk: R3 R5 R6 R2 R11
    for (int k = 0; k < NVEC; k++) begin
      sel = VEC[k][34:33];
      bus_begin();
      send_byte(VEC[k][32:25], a);
      chk(a == VEC[k][8], "R3 chip ack", a, VEC[k][8]);
      send_byte(VEC[k][24:17], a);
      chk(a == VEC[k][8], "R5 word addr ack", a, VEC[k][8]);
      send_byte(VEC[k][16:9], a);
      chk(a == VEC[k][8], "R6 data ack", a, VEC[k][8]);
      bus_end();
      wt(WRC + 100);
      #1;
      v = peek(VEC[k][23:17]);
      #1;
      chk(pdata == VEC[k][7:0], "R6 R2 R11 stored byte", pdata, VEC[k][7:0]);
    end

    // burst, busy refusal, resend, wrap: R6 R7 R8
    sel = 2'b00;
    bus_begin();
    send_byte(8'hA0, a);
    send_byte(8'h7E, a);
    send_byte(8'hD0, a);
    chk(a == 1'b1, "R6 first burst byte ack", a, 1);
    send_byte(8'hD1, a);
    chk(a == 1'b0, "R7 byte in write window refused", a, 0);
    #1; v = peek(7'h7F); #1;
    chk(pdata == 8'h33, "R7 refused byte not stored", pdata, 8'h33);
    wt(WRC + 100);
    send_byte(8'hD1, a);
    chk(a == 1'b1, "R8 resend acked", a, 1);
    wt(WRC + 100);
    send_byte(8'hD2, a);
    chk(a == 1'b1, "R6 wrap byte ack", a, 1);
    bus_end();
    wt(WRC + 100);
    #1; v = peek(7'h7E); #1;
    chk(pdata == 8'hD0, "R6 burst first", pdata, 8'hD0);
    #1; v = peek(7'h7F); #1;
    chk(pdata == 8'hD1, "R8 resend at following address", pdata, 8'hD1);
    #1; v = peek(7'h00); #1;
    chk(pdata == 8'hD2, "R6 address wraps to 0", pdata, 8'hD2);

    // after end event, bytes are not acknowledged: R1
    send_byte(8'hA0, a);
    chk(a == 1'b0, "R1 no ack after end", a, 0);
    send_byte(8'h05, a);
    chk(a == 1'b0, "R1 still idle", a, 0);

    // mid-byte restart: R9
    bus_begin();
    send_byte(8'hA0, a);
    send_byte(8'h50, a);
    for (int i = 0; i < 4; i++) begin
      m_dat = 1'b0; wt(HALF);
      m_clk = 1'b1; wt(HALF);
      m_clk = 1'b0;
    end
    bus_begin();
    send_byte(8'hA0, a);
    chk(a == 1'b1, "R9 chip ack after restart", a, 1);
    send_byte(8'h51, a);
    chk(a == 1'b1, "R9 word addr after restart", a, 1);
    send_byte(8'h5A, a);
    chk(a == 1'b1, "R9 data after restart", a, 1);
    bus_end();
    wt(WRC + 100);
    #1; v = peek(7'h51); #1;
    chk(pdata == 8'h5A, "R9 stored after restart", pdata, 8'h5A);
    chk(pull == 1'b0, "R4 released when idle", pull, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule